// File: doc/BRIEF.md
# Execute and Writeback Slot Selector

This block sits at the execute end of an out-of-order back end. Groups of up to `W` issued instruction slots enter a fixed-delay issue-to-execute pipe. When a group reaches the pipe head, the block walks its slots from index 0 upward and executes them within a budget of `E` functional units. A slot whose instruction has already been squashed is marked executed, but it uses no unit and produces no result. Every instruction that completes is written to the commit group at the same slot index it held on input. Every operation is taken to complete in one cycle.

Completed instructions also send feedback toward the scheduler. A per-slot dependent-wakeup pulse and a physical-register-ready mask are raised for the leading valid commit slots. A mispredicted branch still goes to commit. It also raises a one-cycle squash request that carries the branch's sequence number and its corrected target. When several branches in a group mispredict, the lowest slot index wins. The block then holds a squashing status until the squash is cleared.

The input is a valid/ready stream. `grp_ready` equals "`run` high and not squashing", and a group is taken on any edge where `grp_ready` is high. If `grp_valid` is low on such an edge, an empty group enters the pipe instead. The commit side carries no ready. The consumer applies back-pressure by lowering `run`, which freezes the pipe and empties the commit outputs for that cycle.

Top module: `exwb_slot_select`

## Requirements
- R1: A group is captured on an edge where `grp_ready` is high, which is whenever `run` is high and the block is not squashing. Its results appear on the commit outputs right after the `DELAY`-th following advancing edge. While `grp_valid` is low, an empty group is captured and its per-slot fields are ignored.
- R2: Slots are visited from index 0 upward. The walk stops at the first slot that is not valid, or at a slot reached after `E` slots have used units. `exec_mask` bit i is 1 exactly for visited slots.
- R3: A visited slot with `in_sqd` set uses no unit and has `cmt_slot` bit i equal to 0. Its `in_mis` bit is ignored.
- R4: Each completed slot i drives `cmt_slot` bit i and carries its sequence number at `cmt_seq[i*SEQW +: SEQW]`. Non-completed slots read zero there. `cmt_valid` is the OR of `cmt_slot`.
- R5: The lowest completed slot with `in_mis` set is still committed. In the same cycle it pulses `sq_req` for one cycle, with `sq_seq` and `sq_tgt` taken from that slot.
- R6: `squashing` rises together with `sq_req`. It stays high, keeping `grp_ready` low and producing no commit output, until an edge with `clr_squash` high.
- R7: `wake` bit i is 1 exactly when i < E and `cmt_slot` bits 0..i are all 1.
- R8: `reg_rdy` bit r is 1 exactly when some slot i with `wake` bit i set had `in_dvld` set and destination register index r.
- R9: With `run` low, the pipe holds its contents, `grp_ready` is 0 and all commit, wake, ready and squash outputs are 0.
- R10: After reset all outputs are 0, `grp_ready` follows `run`, and the pipe is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Stage advance enable (back-pressure from commit) |
| clr_squash | input | 1 | Ends the squashing status |
| grp_valid | input | 1 | Input group valid |
| grp_ready | output | 1 | Input group accepted this edge |
| in_vld | input | W | Slot holds an instruction |
| in_sqd | input | W | Slot instruction already squashed |
| in_mis | input | W | Slot is a mispredicted branch |
| in_dvld | input | W | Slot writes a destination register |
| in_seq | input | W*SEQW | Per-slot sequence numbers |
| in_tgt | input | W*PCW | Per-slot computed next PC |
| in_dst | input | W*RIW | Per-slot destination register index |
| exec_mask | output | W | Slots visited (marked executed) |
| cmt_valid | output | 1 | Any commit slot valid |
| cmt_slot | output | W | Commit slot valid mask |
| cmt_seq | output | W*SEQW | Commit sequence numbers |
| wake | output | W | Dependent-wakeup pulse per slot |
| reg_rdy | output | NPREG | Register-ready pulse mask |
| sq_req | output | 1 | Squash/mispredict request pulse |
| sq_seq | output | SEQW | Sequence number of the squashing branch |
| sq_tgt | output | PCW | Corrected target PC |
| squashing | output | 1 | Stage in squashing status |

## Verification
The bench builds the block with W=4, E=2, DELAY=2, SEQW=8, PCW=12 and NPREG=16. At four slots, each slot takes one of four states: empty, squashed, live, or live and mispredicted. That makes all 256 group patterns, and the bench sweeps every one of them. With E=2, the unit budget runs out in the middle of a group. That brings in commit groups with holes, commit slots above E that get no wakeup, several mispredicting branches in one group, and squashed slots that carry a stale mispredict flag. Separate cases cover a frozen pipe, an empty group captured with `grp_valid` low, and the squashing hold.

// File: rtl/exwb_pkg.sv
package exwb_pkg;
  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_SQUASH = 1'b1
  } exwb_state_e;
endpackage

// File: rtl/exwb_issue_pipe.sv
module exwb_issue_pipe #(
  parameter int BITS  = 8,
  parameter int DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);
  logic [BITS-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)   stg[0] <= '0;
    else if (adv) stg[0] <= d;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)   stg[k] <= '0;
      else if (adv) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/exwb_fu_select.sv
module exwb_fu_select #(
  parameter int W    = 4,
  parameter int E    = 2,
  parameter int SEQW = 8,
  parameter int PCW  = 12
) (
  input  logic [W-1:0]      vld,
  input  logic [W-1:0]      sqd,
  input  logic [W-1:0]      mis,
  input  logic [W*SEQW-1:0] seq,
  input  logic [W*PCW-1:0]  tgt,
  output logic [W-1:0]      exec,
  output logic [W-1:0]      done,
  output logic              br_hit,
  output logic [SEQW-1:0]   br_seq,
  output logic [PCW-1:0]    br_tgt
);
  localparam int UW = $clog2(E + 1) + 1;

  logic [UW-1:0] used;
  logic          stop;

  always_comb begin
    exec   = '0;
    done   = '0;
    br_hit = 1'b0;
    br_seq = '0;
    br_tgt = '0;
    used   = '0;
    stop   = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!stop) begin
        if (used == UW'(E) || !vld[i]) begin
          stop = 1'b1;
        end else begin
          exec[i] = 1'b1;
          if (!sqd[i]) begin
            used    = used + 1'b1;
            done[i] = 1'b1;
            if (mis[i] && !br_hit) begin
              br_hit = 1'b1;
              br_seq = seq[i*SEQW +: SEQW];
              br_tgt = tgt[i*PCW +: PCW];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/exwb_wake_gen.sv
module exwb_wake_gen #(
  parameter int W     = 4,
  parameter int E     = 2,
  parameter int NPREG = 16,
  localparam int RIW  = $clog2(NPREG)
) (
  input  logic [W-1:0]     cmt,
  input  logic [W-1:0]     dvld,
  input  logic [W*RIW-1:0] dst,
  output logic [W-1:0]     wake,
  output logic [NPREG-1:0] reg_rdy
);
  logic run_on;

  always_comb begin
    wake   = '0;
    run_on = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (i < E && run_on && cmt[i]) wake[i] = 1'b1;
      else                           run_on = 1'b0;
    end
  end

  always_comb begin
    reg_rdy = '0;
    for (int i = 0; i < W; i++) begin
      if (wake[i] && dvld[i]) reg_rdy[dst[i*RIW +: RIW]] = 1'b1;
    end
  end
endmodule

// File: rtl/exwb_slot_select.sv
module exwb_slot_select
  import exwb_pkg::*;
#(
  parameter int W     = 4,
  parameter int E     = 2,
  parameter int DELAY = 2,
  parameter int SEQW  = 8,
  parameter int PCW   = 12,
  parameter int NPREG = 16,
  localparam int RIW  = $clog2(NPREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr_squash,
  input  logic              grp_valid,
  output logic              grp_ready,
  input  logic [W-1:0]      in_vld,
  input  logic [W-1:0]      in_sqd,
  input  logic [W-1:0]      in_mis,
  input  logic [W-1:0]      in_dvld,
  input  logic [W*SEQW-1:0] in_seq,
  input  logic [W*PCW-1:0]  in_tgt,
  input  logic [W*RIW-1:0]  in_dst,
  output logic [W-1:0]      exec_mask,
  output logic              cmt_valid,
  output logic [W-1:0]      cmt_slot,
  output logic [W*SEQW-1:0] cmt_seq,
  output logic [W-1:0]      wake,
  output logic [NPREG-1:0]  reg_rdy,
  output logic              sq_req,
  output logic [SEQW-1:0]   sq_seq,
  output logic [PCW-1:0]    sq_tgt,
  output logic              squashing
);
  localparam int SLOTB = 4 + SEQW + PCW + RIW;
  localparam int GRPB  = W * SLOTB;

  exwb_state_e state;
  logic        adv;

  assign adv       = run && (state == ST_RUN);
  assign grp_ready = adv;
  assign squashing = (state == ST_SQUASH);

  // Pack input group, unpack pipe head.
  logic [GRPB-1:0]     grp_in, grp_hd;
  logic [W-1:0]        h_vld, h_sqd, h_mis, h_dvld;
  logic [W*SEQW-1:0]   h_seq;
  logic [W*PCW-1:0]    h_tgt;
  logic [W*RIW-1:0]    h_dst;

  for (genvar i = 0; i < W; i++) begin : g_slot
    assign grp_in[i*SLOTB +: SLOTB] = {in_vld[i] & grp_valid, in_sqd[i], in_mis[i],
                                       in_dvld[i], in_seq[i*SEQW +: SEQW],
                                       in_tgt[i*PCW +: PCW], in_dst[i*RIW +: RIW]};
    assign {h_vld[i], h_sqd[i], h_mis[i], h_dvld[i], h_seq[i*SEQW +: SEQW],
            h_tgt[i*PCW +: PCW], h_dst[i*RIW +: RIW]} = grp_hd[i*SLOTB +: SLOTB];
  end

  exwb_issue_pipe #(.BITS(GRPB), .DEPTH(DELAY)) u_pipe (
    .clk(clk), .rst_n(rst_n), .adv(adv), .d(grp_in), .q(grp_hd)
  );

  logic [W-1:0]    s_exec, s_done;
  logic            s_hit;
  logic [SEQW-1:0] s_bseq;
  logic [PCW-1:0]  s_btgt;

  exwb_fu_select #(.W(W), .E(E), .SEQW(SEQW), .PCW(PCW)) u_sel (
    .vld(h_vld), .sqd(h_sqd), .mis(h_mis), .seq(h_seq), .tgt(h_tgt),
    .exec(s_exec), .done(s_done), .br_hit(s_hit), .br_seq(s_bseq), .br_tgt(s_btgt)
  );

  logic [W-1:0]     c_dvld;
  logic [W*RIW-1:0] c_dst;
  logic [W*SEQW-1:0] seq_mask;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign seq_mask[i*SEQW +: SEQW] = {SEQW{s_done[i]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      exec_mask <= '0;
      cmt_slot  <= '0;
      cmt_seq   <= '0;
      c_dvld    <= '0;
      c_dst     <= '0;
      sq_req    <= 1'b0;
      sq_seq    <= '0;
      sq_tgt    <= '0;
    end else begin
      if (adv) begin
        exec_mask <= s_exec;
        cmt_slot  <= s_done;
        cmt_seq   <= h_seq & seq_mask;
        c_dvld    <= h_dvld & s_done;
        c_dst     <= h_dst;
        sq_req    <= s_hit;
        sq_seq    <= s_bseq;
        sq_tgt    <= s_btgt;
        if (s_hit) state <= ST_SQUASH;
      end else begin
        exec_mask <= '0;
        cmt_slot  <= '0;
        cmt_seq   <= '0;
        c_dvld    <= '0;
        sq_req    <= 1'b0;
        sq_seq    <= '0;
        sq_tgt    <= '0;
        if (state == ST_SQUASH && clr_squash) state <= ST_RUN;
      end
    end
  end

  assign cmt_valid = |cmt_slot;

  exwb_wake_gen #(.W(W), .E(E), .NPREG(NPREG)) u_wake (
    .cmt(cmt_slot), .dvld(c_dvld), .dst(c_dst), .wake(wake), .reg_rdy(reg_rdy)
  );
endmodule

// File: rtl/exwb_slot_select_chk.sv
module exwb_slot_select_chk #(
  parameter int W = 4,
  parameter int E = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         grp_ready,
  input logic         squashing,
  input logic         cmt_valid,
  input logic [W-1:0] cmt_slot,
  input logic [W-1:0] exec_mask,
  input logic [W-1:0] wake,
  input logic         sq_req
);
  // R6
  squash_sets_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_req |-> squashing);
  // R6
  squash_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squashing |-> !grp_ready);
  // R5
  squash_with_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_req |-> cmt_valid);
  // R3
  commit_within_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_slot & ~exec_mask) == '0);
  // R2
  unit_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmt_slot) <= E);
  // R7
  wake_in_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake & ~cmt_slot) == '0);
  // R9
  frozen_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !cmt_valid && !sq_req);
endmodule

bind exwb_slot_select exwb_slot_select_chk #(.W(W), .E(E)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .grp_ready(grp_ready),
  .squashing(squashing), .cmt_valid(cmt_valid), .cmt_slot(cmt_slot),
  .exec_mask(exec_mask), .wake(wake), .sq_req(sq_req)
);

// File: tb/tb_exwb_slot_select.sv
`timescale 1ns/1ps
module tb_exwb_slot_select;
  localparam int W = 4, E = 2, DELAY = 2, SEQW = 8, PCW = 12, NPREG = 16, RIW = 4;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, clr_squash = 1'b0, grp_valid = 1'b0;
  logic grp_ready;
  logic [W-1:0] in_vld = '0, in_sqd = '0, in_mis = '0, in_dvld = '0;
  logic [W*SEQW-1:0] in_seq = '0;
  logic [W*PCW-1:0]  in_tgt = '0;
  logic [W*RIW-1:0]  in_dst = '0;
  logic [W-1:0] exec_mask, cmt_slot, wake;
  logic cmt_valid, sq_req, squashing;
  logic [W*SEQW-1:0] cmt_seq;
  logic [NPREG-1:0] reg_rdy;
  logic [SEQW-1:0] sq_seq;
  logic [PCW-1:0] sq_tgt;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  exwb_slot_select #(.W(W), .E(E), .DELAY(DELAY), .SEQW(SEQW), .PCW(PCW), .NPREG(NPREG)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .clr_squash(clr_squash),
    .grp_valid(grp_valid), .grp_ready(grp_ready),
    .in_vld(in_vld), .in_sqd(in_sqd), .in_mis(in_mis), .in_dvld(in_dvld),
    .in_seq(in_seq), .in_tgt(in_tgt), .in_dst(in_dst),
    .exec_mask(exec_mask), .cmt_valid(cmt_valid), .cmt_slot(cmt_slot),
    .cmt_seq(cmt_seq), .wake(wake), .reg_rdy(reg_rdy), .sq_req(sq_req),
    .sq_seq(sq_seq), .sq_tgt(sq_tgt), .squashing(squashing)
  );

  task automatic chk(input string req, input string what, input logic [63:0] got,
                     input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Slot state per pattern: 0 empty, 1 squashed, 2 live, 3 live mispredicted.
  task automatic load(input int p, input bit gv);
    grp_valid = gv;
    for (int i = 0; i < W; i++) begin
      int c;
      c = (p >> (2*i)) & 3;
      in_vld[i]  = (c != 0);
      in_sqd[i]  = (c == 1);
      in_mis[i]  = (c == 3) || (c == 1 && (i % 2) == 1);
      in_dvld[i] = (i != (p % 4));
      in_seq[i*SEQW +: SEQW] = SEQW'(((p & 63) << 2) | i);
      in_tgt[i*PCW +: PCW]   = PCW'(256 + p*4 + i);
      in_dst[i*RIW +: RIW]   = RIW'((p + 5*i) % 16);
    end
  endtask

  task automatic check_pattern(input int p);
    logic [W-1:0] e_exec, e_cmt, e_wake;
    logic [W*SEQW-1:0] e_seq;
    logic [NPREG-1:0] e_rdy;
    logic e_sq, cont, stop;
    logic [SEQW-1:0] e_sseq;
    logic [PCW-1:0] e_stgt;
    int used;
    e_exec = '0; e_cmt = '0; e_wake = '0; e_seq = '0; e_rdy = '0;
    e_sq = 0; e_sseq = '0; e_stgt = '0; used = 0; stop = 0; cont = 1;
    for (int i = 0; i < W; i++) begin
      int c;
      c = (p >> (2*i)) & 3;
      if (!stop) begin
        if (used == E || c == 0) stop = 1;
        else begin
          e_exec[i] = 1;
          if (c != 1) begin
            used++;
            e_cmt[i] = 1;
            e_seq[i*SEQW +: SEQW] = SEQW'(((p & 63) << 2) | i);
            if (c == 3 && !e_sq) begin
              e_sq = 1;
              e_sseq = SEQW'(((p & 63) << 2) | i);
              e_stgt = PCW'(256 + p*4 + i);
            end
          end
        end
      end
    end
    for (int i = 0; i < W; i++) begin
      if (i < E && cont && e_cmt[i]) begin
        e_wake[i] = 1;
        if (i != (p % 4)) e_rdy[(p + 5*i) % 16] = 1;
      end else cont = 0;
    end
    chk("R2", $sformatf("exec_mask p=%0h", p), 64'(exec_mask), 64'(e_exec));
    chk("R3", $sformatf("cmt_slot p=%0h", p), 64'(cmt_slot), 64'(e_cmt));
    chk("R4", $sformatf("cmt_seq p=%0h", p), 64'(cmt_seq), 64'(e_seq));
    chk("R4", $sformatf("cmt_valid p=%0h", p), 64'(cmt_valid), 64'(|e_cmt));
    chk("R7", $sformatf("wake p=%0h", p), 64'(wake), 64'(e_wake));
    chk("R8", $sformatf("reg_rdy p=%0h", p), 64'(reg_rdy), 64'(e_rdy));
    chk("R5", $sformatf("sq_req p=%0h", p), 64'(sq_req), 64'(e_sq));
    if (e_sq) begin
      chk("R5", $sformatf("sq_seq p=%0h", p), 64'(sq_seq), 64'(e_sseq));
      chk("R5", $sformatf("sq_tgt p=%0h", p), 64'(sq_tgt), 64'(e_stgt));
    end
    chk("R6", $sformatf("squashing p=%0h", p), 64'(squashing), 64'(e_sq));
    if (e_sq) begin
      @(negedge clk);
      chk("R6", $sformatf("hold ready p=%0h", p), 64'(grp_ready), 64'd0);
      chk("R6", $sformatf("hold cmt p=%0h", p), 64'(cmt_valid), 64'd0);
      clr_squash = 1'b1;
      @(negedge clk);
      clr_squash = 1'b0;
      chk("R6", $sformatf("cleared p=%0h", p), 64'(grp_ready), 64'd1);
    end
  endtask

  task automatic run_pattern(input int p);
    @(negedge clk);
    load(p, 1'b1);
    @(posedge clk);
    @(negedge clk);
    grp_valid = 1'b0;
    repeat (DELAY) @(posedge clk);
    @(negedge clk);
    check_pattern(p);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10", "cmt_valid", 64'(cmt_valid), 64'd0);
    chk("R10", "squashing", 64'(squashing), 64'd0);
    chk("R10", "sq_req", 64'(sq_req), 64'd0);
    chk("R10", "ready with run low", 64'(grp_ready), 64'd0);
    run = 1'b1;
    #0.1;
    chk("R10", "ready follows run", 64'(grp_ready), 64'd1);

    for (int p = 0; p < 256; p++) run_pattern(p);

    // R1 group with grp_valid low is empty
    @(negedge clk);
    load(8'hAA, 1'b0);
    repeat (DELAY + 1) @(posedge clk);
    @(negedge clk);
    chk("R1", "empty group exec", 64'(exec_mask), 64'd0);
    chk("R1", "empty group cmt", 64'(cmt_valid), 64'd0);

    // R9 freeze: capture all-live group, stall, then release
    @(negedge clk);
    load(8'hAA, 1'b1);
    @(posedge clk);
    @(negedge clk);
    grp_valid = 1'b0;
    run = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R9", "frozen cmt", 64'(cmt_valid), 64'd0);
      chk("R9", "frozen ready", 64'(grp_ready), 64'd0);
    end
    run = 1'b1;
    repeat (DELAY - 1) @(posedge clk);
    @(negedge clk);
    chk("R9", "not yet out", 64'(cmt_valid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R1", "released cmt_slot", 64'(cmt_slot), 64'b0011);
    chk("R9", "released wake", 64'(wake), 64'b0011);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule